// File: doc/BRIEF.md
# Case-Insensitive Keyword Stream Matcher

This block scans a stream of text for a stored keyword. It takes one 32-bit beat per clock. Each beat holds four consecutive ASCII characters, and the block reports every position where the keyword ends, ignoring upper and lower case. Before a file is streamed, a host writes the keyword one byte at a time and then writes the keyword length. Both the text and the stored keyword are folded to lower case. Four comparator lanes then test all four candidate end positions of the beat at the same time. The block never asks the source to wait.

A history of the most recent characters of the current file is kept, so a keyword that straddles beat boundaries is still found. The history is discarded at the end of each file. Results come out one cycle after the beat: a lane mask, the index of the beat within its file, and at the end of each file a completion pulse with the total number of matches.

Top module: `kwm_top`

## Requirements
- R1: A beat is accepted in every cycle in which `in_valid` is high, with no stall. Its result appears on `hit_valid`/`hit_mask` in the following cycle. `hit_valid` is high exactly when that mask is nonzero.
- R2: Bytes 0x41..0x5A are compared as 0x61..0x7A, in both the text and the stored keyword. Every other byte is compared unchanged, so for example 0x40 never equals 0x60.
- R3: Character i of a beat is `in_data[8*i+7:8*i]`, and character 0 comes first in text order. Bit i of `hit_mask` is set when the last `len` characters of the file that end at character i equal the keyword. Overlapping occurrences are all reported.
- R4: A match whose characters are spread over several beats is detected for every keyword length from 1 to MAXLEN.
- R5: `hit_beat` gives the zero-based index of the reported beat within its file. The ending byte offset is 4*`hit_beat`+lane.
- R6: A beat with `in_last` high ends a file. No match ever uses characters from two different files.
- R7: On a beat with `in_last` high, only characters 0..`in_bytes`-1 are used, and lanes at or above `in_bytes` never report a match. On other beats `in_bytes` is ignored.
- R8: A length of 0 or greater than MAXLEN sets `len_bad`, and no match is reported while it is set.
- R9: In the cycle after a last beat, `done` pulses for one cycle. In the same cycle `hit_total` shows the number of mask bits reported for that file, and it holds that value afterwards.
- R10: After reset, `len_bad`=1, `hit_valid`=0, `hit_mask`=0, `done`=0 and `hit_total`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kw_we | input | 1 | Write one keyword byte |
| kw_idx | input | clog2(MAXLEN) | Keyword byte position, 0 = first character |
| kw_byte | input | 8 | Keyword byte value |
| len_we | input | 1 | Write keyword length |
| len_in | input | clog2(MAXLEN+1) | Keyword length |
| len_bad | output | 1 | Stored length is invalid |
| in_valid | input | 1 | Text beat present |
| in_data | input | 8*LANES | Four text characters, character 0 in the low byte |
| in_last | input | 1 | Beat ends the file |
| in_bytes | input | clog2(LANES+1) | Characters used on a last beat |
| hit_valid | output | 1 | At least one lane matched on the previous beat |
| hit_mask | output | LANES | Lanes where a match ended |
| hit_beat | output | BEATW | Beat index within file of the reported beat |
| done | output | 1 | File finished, count valid |
| hit_total | output | CNTW | Match count of the last finished file |

## Verification
The hardest cases to reach are a keyword that could only match by joining the tail of one file to the head of the next, and a short final beat whose unused lanes hold characters that would complete a match. The stimulus table ends one file with characters that, together with the next file's first character, spell the keyword. A later last beat declares only two characters, while its third carries the closing letter of a match. A full-length keyword is also streamed across five beats, so that the history is used at its full depth.

// File: rtl/kwm_pkg.sv
package kwm_pkg;

  // Map upper-case ASCII letters onto lower case; all other bytes unchanged.
  function automatic logic [7:0] fold_case(input logic [7:0] c);
    if (c >= 8'h41 && c <= 8'h5A) return c | 8'h20;
    return c;
  endfunction

  // Number of set bits in a lane mask.
  function automatic int unsigned lane_pop(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 32; b++) n += int'(v[b]);
    return n;
  endfunction

  // Characters held after one more beat, capped at the history depth.
  function automatic int unsigned fill_next(input int unsigned cur, input int unsigned add,
                                            input int unsigned cap);
    if (cur + add >= cap) return cap;
    return cur + add;
  endfunction

endpackage

// File: rtl/kwm_store.sv
module kwm_store #(
  parameter int MAXLEN = 16,
  localparam int IDXW = $clog2(MAXLEN),
  localparam int LENW = $clog2(MAXLEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  kw_we,
  input  logic [IDXW-1:0]       kw_idx,
  input  logic [7:0]            kw_byte,
  input  logic                  len_we,
  input  logic [LENW-1:0]       len_in,
  output logic [MAXLEN*8-1:0]   kw_flat,
  output logic [LENW-1:0]       len_q,
  output logic                  len_ok
);
  import kwm_pkg::*;

  logic [7:0] kw_q [MAXLEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXLEN; i++) kw_q[i] <= 8'h00;
    end else if (kw_we) begin
      kw_q[kw_idx] <= fold_case(kw_byte);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      len_ok <= 1'b0;
    end else if (len_we) begin
      len_q  <= len_in;
      len_ok <= (len_in != '0) && (int'(len_in) <= MAXLEN);
    end
  end

  for (genvar g = 0; g < MAXLEN; g++) begin : g_flat
    assign kw_flat[g*8 +: 8] = kw_q[g];
  end

  // R8
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_ok |-> (len_q != '0 && int'(len_q) <= MAXLEN));

  // R2
  kw_folded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kw_we |=> (kw_q[$past(kw_idx)] < 8'h41 || kw_q[$past(kw_idx)] > 8'h5A));

endmodule

// File: rtl/kwm_window.sv
module kwm_window #(
  parameter int MAXLEN = 16,
  parameter int LANES  = 4,
  localparam int LENW = $clog2(MAXLEN + 1),
  localparam int WINB = MAXLEN - 1 + LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  logic                  last,
  input  logic [LANES*8-1:0]    data_in,
  output logic [WINB*8-1:0]     win_flat,
  output logic [LENW-1:0]       fill
);
  import kwm_pkg::*;

  logic [(MAXLEN-1)*8-1:0] hist_q;
  logic [LANES*8-1:0]      folded;

  for (genvar g = 0; g < LANES; g++) begin : g_fold
    assign folded[g*8 +: 8] = fold_case(data_in[g*8 +: 8]);
  end

  // oldest byte at index 0; new character i lands at index MAXLEN-1+i
  assign win_flat = {folded, hist_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill   <= '0;
    end else if (adv) begin
      hist_q <= win_flat[WINB*8-1 -: (MAXLEN-1)*8];
      if (last) fill <= '0;
      else      fill <= LENW'(fill_next(int'(fill), LANES, MAXLEN));
    end
  end

  // R4
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= MAXLEN);

  // R6
  file_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last) |=> fill == '0);

endmodule

// File: rtl/kwm_lane.sv
module kwm_lane #(
  parameter int MAXLEN = 16,
  parameter int LANES  = 4,
  parameter int LANE   = 0,
  localparam int LENW = $clog2(MAXLEN + 1),
  localparam int WINB = MAXLEN - 1 + LANES
) (
  input  logic [WINB*8-1:0]     win_flat,
  input  logic [MAXLEN*8-1:0]   kw_flat,
  input  logic [LENW-1:0]       len,
  input  logic [LENW-1:0]       fill,
  input  logic                  en,
  output logic                  hit
);
  localparam int ENDPOS = MAXLEN - 1 + LANE;

  logic eq;
  int   l;
  int   avail;

  always_comb begin
    l     = int'(len);
    avail = int'(fill) + LANE + 1;
    eq    = 1'b1;
    for (int k = 0; k < MAXLEN; k++) begin
      if (k < l) begin
        if (win_flat[(ENDPOS-k)*8 +: 8] != kw_flat[(l-1-k)*8 +: 8]) eq = 1'b0;
      end
    end
    hit = en && eq && (l != 0) && (avail >= l);
  end

endmodule

// File: rtl/kwm_top.sv
module kwm_top #(
  parameter int MAXLEN = 16,
  parameter int LANES  = 4,
  parameter int BEATW  = 16,
  parameter int CNTW   = 16,
  localparam int IDXW = $clog2(MAXLEN),
  localparam int LENW = $clog2(MAXLEN + 1),
  localparam int NBW  = $clog2(LANES + 1),
  localparam int WINB = MAXLEN - 1 + LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kw_we,
  input  logic [IDXW-1:0]    kw_idx,
  input  logic [7:0]         kw_byte,
  input  logic               len_we,
  input  logic [LENW-1:0]    len_in,
  output logic               len_bad,
  input  logic               in_valid,
  input  logic [LANES*8-1:0] in_data,
  input  logic               in_last,
  input  logic [NBW-1:0]     in_bytes,
  output logic               hit_valid,
  output logic [LANES-1:0]   hit_mask,
  output logic [BEATW-1:0]   hit_beat,
  output logic               done,
  output logic [CNTW-1:0]    hit_total
);
  import kwm_pkg::*;

  logic [MAXLEN*8-1:0] kw_flat;
  logic [LENW-1:0]     len_q;
  logic                len_ok;
  logic [WINB*8-1:0]   win_flat;
  logic [LENW-1:0]     fill;
  logic [LANES-1:0]    lane_en;
  logic [LANES-1:0]    lane_hit;
  logic [BEATW-1:0]    beat_q;
  logic [CNTW-1:0]     acc_q;
  logic [CNTW-1:0]     acc_sum;

  kwm_store #(.MAXLEN(MAXLEN)) u_store (
    .clk(clk), .rst_n(rst_n), .kw_we(kw_we), .kw_idx(kw_idx), .kw_byte(kw_byte),
    .len_we(len_we), .len_in(len_in), .kw_flat(kw_flat), .len_q(len_q), .len_ok(len_ok)
  );

  kwm_window #(.MAXLEN(MAXLEN), .LANES(LANES)) u_win (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .last(in_last), .data_in(in_data),
    .win_flat(win_flat), .fill(fill)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = in_valid && len_ok && (!in_last || (NBW'(g) < in_bytes));
    kwm_lane #(.MAXLEN(MAXLEN), .LANES(LANES), .LANE(g)) u_lane (
      .win_flat(win_flat), .kw_flat(kw_flat), .len(len_q), .fill(fill),
      .en(lane_en[g]), .hit(lane_hit[g])
    );
  end

  assign len_bad = !len_ok;
  assign acc_sum = acc_q + CNTW'(lane_pop(32'(lane_hit)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_mask  <= '0;
      hit_beat  <= '0;
      beat_q    <= '0;
      acc_q     <= '0;
      done      <= 1'b0;
      hit_total <= '0;
    end else begin
      hit_valid <= |lane_hit;
      hit_mask  <= lane_hit;
      hit_beat  <= beat_q;
      done      <= in_valid && in_last;
      if (in_valid) begin
        if (in_last) begin
          beat_q    <= '0;
          acc_q     <= '0;
          hit_total <= acc_sum;
        end else begin
          beat_q <= beat_q + 1'b1;
          acc_q  <= acc_sum;
        end
      end
    end
  end

  // R1
  hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(in_valid));

  // R7
  tail_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && $past(in_valid && in_last)) |-> (32'(hit_mask) >> $past(in_bytes)) == 0);

  // R8
  bad_len_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_bad |=> !hit_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  // R1
  mask_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid == ($countones(hit_mask) != 0));

endmodule

// File: tb/sim_kwm_top.sv
`timescale 1ns/1ps
module sim_kwm_top;
  localparam int MAXLEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kw_we = 1'b0;
  logic [3:0]  kw_idx = '0;
  logic [7:0]  kw_byte = '0;
  logic        len_we = 1'b0;
  logic [4:0]  len_in = '0;
  logic        len_bad;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [2:0]  in_bytes = '0;
  logic        hit_valid;
  logic [3:0]  hit_mask;
  logic [15:0] hit_beat;
  logic        done;
  logic [15:0] hit_total;

  kwm_top u0 (.*);

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench-side model state
  logic [7:0] kwf [MAXLEN];
  int         klen = 0;
  logic [7:0] fbuf [0:1023];
  int         fpos = 0;
  int         bbeat = 0;
  int         ftot = 0;
  bit         p_valid = 0;
  bit         p_last = 0;
  logic [3:0] p_mask = '0;
  int         p_beat = 0;
  int         p_total = 0;
  string      p_tag = "";

  function automatic logic [7:0] lower(input logic [7:0] c);
    return (c inside {[8'h41:8'h5A]}) ? c + 8'd32 : c;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_prev();
    if (p_valid) begin
      chk(p_tag, "hit_valid", hit_valid, p_mask != 0);
      chk(p_tag, "hit_mask", hit_mask, p_mask);
      if (p_mask != 0) chk("R5", "hit_beat", hit_beat, p_beat);
      if (p_last) begin
        chk("R9", "done", done, 1);
        chk("R9", "hit_total", hit_total, p_total);
      end else chk("R9", "done idle", done, 0);
    end
  endtask

  // str holds four characters in text order, first character in the top byte
  task automatic beat(input logic [31:0] str, input bit last, input int nb, input string tag);
    @(negedge clk);
    check_prev();
    in_valid = 1'b1;
    in_last  = last;
    in_bytes = 3'(nb);
    for (int i = 0; i < 4; i++) in_data[i*8 +: 8] = str[31-8*i -: 8];
    p_mask = '0;
    for (int i = 0; i < 4; i++) begin
      if (!last || i < nb) begin
        bit m;
        fbuf[fpos] = lower(str[31-8*i -: 8]);
        fpos++;
        m = (klen >= 1 && klen <= MAXLEN && fpos >= klen);
        for (int k = 0; k < klen && m; k++)
          if (fbuf[fpos-klen+k] != kwf[k]) m = 0;
        p_mask[i] = m;
      end
    end
    ftot += $countones(p_mask);
    p_valid = 1;
    p_last  = last;
    p_beat  = bbeat;
    p_tag   = tag;
    p_total = ftot;
    if (last) begin
      bbeat = 0; fpos = 0; ftot = 0;
    end else bbeat++;
  endtask

  task automatic idle();
    @(negedge clk);
    check_prev();
    in_valid = 1'b0;
    in_last  = 1'b0;
    p_valid  = 0;
  endtask

  task automatic load_kw(input string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      kw_we = 1'b1; kw_idx = 4'(i); kw_byte = s[i];
      kwf[i] = lower(s[i]);
    end
    @(negedge clk);
    kw_we = 1'b0;
    set_len(s.len());
  endtask

  task automatic set_len(input int n);
    @(negedge clk);
    len_we = 1'b1; len_in = 5'(n);
    klen = n;
    @(negedge clk);
    len_we = 1'b0;
  endtask

  function automatic string rtag(input int n);
    case (n)
      1: return "R1";
      3: return "R3";
      6: return "R6";
      7: return "R7";
      default: return "R2";
    endcase
  endfunction

  typedef struct packed {
    logic [31:0] s;
    logic        last;
    logic [2:0]  nb;
    logic [3:0]  rq;
  } row_t;

  // keyword "aBa"; rows stream back to back
  localparam row_t TBL [7] = '{
    '{"xABA", 1'b0, 3'd0, 4'd3},  // overlapping occurrences
    '{"BAba", 1'b0, 3'd0, 4'd3},
    '{"b@`A", 1'b0, 3'd0, 4'd2},  // non-letters kept apart
    '{"qaAB", 1'b1, 3'd4, 4'd1},  // file ends with "...AB"
    '{"Axyz", 1'b0, 3'd0, 4'd6},  // "A" would complete across files
    '{"abAB", 1'b1, 3'd2, 4'd7},  // third character would match if used
    '{"ABAB", 1'b1, 3'd4, 4'd1}   // one-beat file
  };

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10", "len_bad", len_bad, 1);
    chk("R10", "hit_valid", hit_valid, 0);
    chk("R10", "hit_mask", hit_mask, 0);
    chk("R10", "done", done, 0);
    chk("R10", "hit_total", hit_total, 0);

    load_kw("aBa");
    chk("R8", "len_bad valid", len_bad, 0);
    foreach (TBL[r]) beat(TBL[r].s, TBL[r].last, int'(TBL[r].nb), rtag(int'(TBL[r].rq)));
    idle();

    // R8: zero length
    set_len(0);
    chk("R8", "len_bad zero", len_bad, 1);
    beat("abaa", 1'b1, 4, "R8");
    idle();
    // R8: too long
    set_len(17);
    chk("R8", "len_bad long", len_bad, 1);
    beat("aaaa", 1'b0, 0, "R8");
    beat("aaaa", 1'b1, 4, "R8");
    idle();

    // R4: full-length keyword spanning five beats
    load_kw("0123456789ABCDEF");
    beat("zz01", 1'b0, 0, "R4");
    beat("2345", 1'b0, 0, "R4");
    beat("6789", 1'b0, 0, "R4");
    beat("abcd", 1'b0, 0, "R4");
    beat("efzz", 1'b1, 4, "R4");
    idle();

    // R2: '@' must not equal '`', letters fold
    load_kw("@");
    beat("`@`@", 1'b1, 4, "R2");
    idle();
    load_kw("Q");
    beat("qQxq", 1'b1, 4, "R2");
    idle();
    idle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule